// File: doc/BRIEF.md
# DDR2 On-Die-Termination Timing Generator

This block drives the on-die-termination (ODT) enable pin of a DDR2 memory. It works from the command strobe of the memory controller. Each command is tagged as a read or a write. The block places an ODT window of whole clock cycles around every write burst. It assumes the memory turns termination on two clocks after ODT rises and off two and a half clocks after ODT falls. The window starts from the programmed CAS latency, and the write latency is taken as one less than the CAS latency.

An early-termination mode is available. In this mode the window opens one clock sooner and closes one clock later. The mode needs a larger minimum CAS latency, and it stretches the read-to-write turnaround by one clock. When the configuration is illegal, a registered flag is raised and ODT is held low.

The block also produces a write-permit output. After every read, this output stays low until the programmed turnaround has elapsed. The controller must not issue a write while it is low.

Top module: `ddr2_odt_gen`

## Requirements
- R1: While `rst` is high and after it falls with no command given, `odt` is 0, `cfg_err` is 0 and `wr_permit` is 1.
- R2: With `early_en`=0 and `cas_lat` below 4, `cfg_err` is 1 from the clock edge after the setting, and `odt` stays 0 even after writes.
- R3: With `early_en`=0 and a legal latency CL, a write sampled at edge e (`cmd_valid`=1, `cmd_is_write`=1) makes `odt` 1 after edges e+CL-3 through e+CL. That is four cycles, and `odt` is 0 on either side.
- R4: With `early_en`=1 and `cas_lat` below 5, `cfg_err` is 1 and `odt` stays 0 even after writes.
- R5: With `early_en`=1 and a legal latency CL, a write sampled at edge e makes `odt` 1 after edges e+CL-4 through e+CL+1. That is six cycles.
- R6: When the windows of two writes overlap or abut, `odt` stays 1 over their union with no low cycle between them.
- R7: With `early_en`=0, a read sampled at edge e (`cmd_is_write`=0) with gap G on `rd2wr_gap` makes `wr_permit` 0 after edges e through e+G-1 and 1 again from edge e+G. When G=0, `wr_permit` never drops.
- R8: With `early_en`=1, the turnaround after a read is G+1 cycles instead of G.
- R9: A read command never raises `odt`.
- R10: A read arriving while `wr_permit` is low restarts the turnaround count from that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_is_write | input | 1 | 1 = write, 0 = read |
| cas_lat | input | CL_W | Programmed CAS latency in clocks |
| early_en | input | 1 | Early/extended ODT mode |
| rd2wr_gap | input | GAP_W | Memory read-to-write turnaround in clocks |
| odt | output | 1 | ODT pin level (registered) |
| cfg_err | output | 1 | Illegal latency for the selected mode (registered) |
| wr_permit | output | 1 | 1 when a write may be issued (registered) |

## Verification
Each output is a single register, so every result is counted in clock edges from the edge that sampled the command. `odt` follows a write by CL-3 edges in normal mode and CL-4 edges in early mode. `wr_permit` falls on the same edge that samples a read. `cfg_err` follows a configuration change by one edge.

For each scenario the bench works out an expected triple for every edge index and queues it. It drives each command half a cycle before its sampling edge. The monitor compares outputs at the falling edge that follows the edge the item names, so it checks neither a cycle early nor a cycle late. Scenarios are separated by idle gaps longer than any window or turnaround, so no scenario carries state into the next.

// File: rtl/ddr2_odt_pkg.sv
package ddr2_odt_pkg;
  // Command kind carried on cmd_is_write
  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_kind_e;

  // Minimum CAS latency per mode
  localparam int NORM_MIN_CL  = 4;
  localparam int EARLY_MIN_CL = 5;

  // ODT rise offset from a write = WL - tAOND = (CL - 1) - 2
  localparam int RISE_OFS     = 3;

  // Window lengths in clocks: a 4-beat burst plus turn-off margin
  localparam int NORM_LEN     = 4;
  localparam int EARLY_LEN    = NORM_LEN + 2;
endpackage

// File: rtl/odt_cfg_check.sv
module odt_cfg_check
  import ddr2_odt_pkg::*;
#(
  parameter int CL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CL_W-1:0] cas_lat,
  input  logic            early_en,
  output logic            cfg_bad,
  output logic            cfg_err
);
  localparam logic [CL_W-1:0] MIN_N = CL_W'(NORM_MIN_CL);
  localparam logic [CL_W-1:0] MIN_E = CL_W'(EARLY_MIN_CL);

  always_comb begin
    if (early_en) cfg_bad = (cas_lat < MIN_E);
    else          cfg_bad = (cas_lat < MIN_N);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_bad;
  end
endmodule

// File: rtl/odt_window.sv
module odt_window
  import ddr2_odt_pkg::*;
#(
  parameter int CL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_fire,
  input  logic [CL_W-1:0] cas_lat,
  input  logic            early_en,
  input  logic            cfg_bad,
  output logic            odt
);
  localparam int HD = 2 ** CL_W;   // history depth covers CL + 1
  localparam int OW = CL_W + 1;

  logic [HD-1:0] hist;   // hist[i]: write sampled i+1 edges before now
  logic [HD-1:0] mask;
  logic [OW-1:0] lo, hi;
  logic          wr_hit;

  always_comb begin
    lo = {1'b0, cas_lat} - OW'(RISE_OFS) - OW'(early_en);
    if (early_en) hi = lo + OW'(EARLY_LEN - 1);
    else          hi = lo + OW'(NORM_LEN - 1);
  end

  genvar i;
  generate
    for (i = 0; i < HD; i++) begin : g_mask
      assign mask[i] = (OW'(i + 1) >= lo) && (OW'(i + 1) <= hi);
    end
  endgenerate

  // Overlapping windows merge through the OR reduction
  assign wr_hit = |(hist & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      odt  <= 1'b0;
    end else begin
      hist <= {hist[HD-2:0], wr_fire};
      odt  <= wr_hit && !cfg_bad;
    end
  end

  // R9: with no write in the history, ODT cannot be driven high
  assert_quiet_without_write_R9: assert property (
    @(posedge clk) disable iff (rst) (hist == '0) |=> !odt);
endmodule

// File: rtl/rd2wr_timer.sv
module rd2wr_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_fire,
  input  logic [GAP_W-1:0] gap,
  input  logic             early_en,
  output logic             wr_permit
);
  localparam int CW = GAP_W + 1;

  logic [CW-1:0] cnt, cnt_nx, gap_eff;

  always_comb begin
    gap_eff = {1'b0, gap} + CW'(early_en);
    if (rd_fire)        cnt_nx = gap_eff;
    else if (cnt != '0) cnt_nx = cnt - CW'(1);
    else                cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      wr_permit <= 1'b1;
    end else begin
      cnt       <= cnt_nx;
      wr_permit <= (cnt_nx == '0);
    end
  end

  assert_permit_drops_R7: assert property (
    @(posedge clk) disable iff (rst)
    (rd_fire && gap_eff != '0) |=> !wr_permit);

  assert_count_steps_R10: assert property (
    @(posedge clk) disable iff (rst)
    (!rd_fire && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/ddr2_odt_gen.sv
module ddr2_odt_gen
  import ddr2_odt_pkg::*;
#(
  parameter int CL_W  = 4,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_is_write,
  input  logic [CL_W-1:0]  cas_lat,
  input  logic             early_en,
  input  logic [GAP_W-1:0] rd2wr_gap,
  output logic             odt,
  output logic             cfg_err,
  output logic             wr_permit
);
  cmd_kind_e kind;
  logic      wr_fire, rd_fire, cfg_bad;

  assign kind    = cmd_kind_e'(cmd_is_write);
  assign wr_fire = cmd_valid && (kind == CMD_WR);
  assign rd_fire = cmd_valid && (kind == CMD_RD);

  odt_cfg_check #(.CL_W(CL_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cas_lat (cas_lat),
    .early_en(early_en),
    .cfg_bad (cfg_bad),
    .cfg_err (cfg_err)
  );

  odt_window #(.CL_W(CL_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .cas_lat (cas_lat),
    .early_en(early_en),
    .cfg_bad (cfg_bad),
    .odt     (odt)
  );

  rd2wr_timer #(.GAP_W(GAP_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .gap      (rd2wr_gap),
    .early_en (early_en),
    .wr_permit(wr_permit)
  );

  // R2 / R4: an illegal setting never coexists with termination on
  assert_err_blocks_odt_R2: assert property (
    @(posedge clk) disable iff (rst) cfg_err |-> !odt);
endmodule

// File: tb/sim_ddr2_odt_gen.sv
module sim_ddr2_odt_gen;
  localparam int LEN = 24;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid, cmd_is_write, early_en;
  logic [3:0] cas_lat, rd2wr_gap;
  logic       odt, cfg_err, wr_permit;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    int    cyc;
    logic  odt;
    logic  wp;
    logic  err;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int   cmd_at[LEN+1];   // 0 idle, 1 write, 2 read

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  ddr2_odt_gen u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .cas_lat(cas_lat), .early_en(early_en), .rd2wr_gap(rd2wr_gap),
    .odt(odt), .cfg_err(cfg_err), .wr_permit(wr_permit)
  );

  // Monitor: compare each queued expectation at its cycle
  always @(negedge clk) begin
    if (q.size() != 0 && q[0].cyc == cyc) begin
      it = q.pop_front();
      tests++;
      if (odt !== it.odt || wr_permit !== it.wp || cfg_err !== it.err) begin
        fails++;
        $display("FAIL %s cyc %0d: odt/wp/err = %b%b%b expected %b%b%b",
                 it.tag, cyc, odt, wr_permit, cfg_err, it.odt, it.wp, it.err);
      end
    end
  end

  task automatic clear_cmds();
    for (int k = 0; k <= LEN; k++) cmd_at[k] = 0;
  endtask

  // Driver: compute expectations, queue them, then play the commands
  task automatic run_scn(input int cl, input bit early, input int gap, input string tag);
    int b, lo, hi, geff, lastrd;
    bit bad, eo, ew;
    exp_t e;
    @(negedge clk);
    cas_lat = 4'(cl); early_en = early; rd2wr_gap = 4'(gap);
    repeat (20) @(negedge clk);
    bad  = early ? (cl < 5) : (cl < 4);
    lo   = early ? cl - 4 : cl - 3;
    hi   = early ? cl + 1 : cl;
    geff = gap + (early ? 1 : 0);
    b    = cyc;
    for (int m = 1; m < LEN; m++) begin
      eo = 1'b0; ew = 1'b1; lastrd = -1;
      for (int w = 1; w <= m; w++) begin
        if (cmd_at[w] == 1 && !bad && (m - w) >= lo && (m - w) <= hi) eo = 1'b1;
        if (cmd_at[w] == 2) lastrd = w;
      end
      if (lastrd >= 0 && (m - lastrd) < geff) ew = 1'b0;
      e.cyc = b + m; e.odt = eo; e.wp = ew; e.err = bad; e.tag = tag;
      q.push_back(e);
    end
    for (int k = 0; k < LEN; k++) begin
      cmd_valid    = (cmd_at[k+1] != 0);
      cmd_is_write = (cmd_at[k+1] == 1);
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_is_write = 1'b0;
    repeat (20) @(negedge clk);
    clear_cmds();
  endtask

  task automatic check_reset(input string tag);
    tests++;
    if (odt !== 1'b0 || cfg_err !== 1'b0 || wr_permit !== 1'b1) begin
      fails++;
      $display("FAIL %s: odt/err/wp = %b%b%b expected 001", tag, odt, cfg_err, wr_permit);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_is_write = 1'b0;
    cas_lat = 4'd5; early_en = 1'b0; rd2wr_gap = 4'd0;
    clear_cmds();
    repeat (3) @(negedge clk);
    check_reset("R1 in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_reset("R1 after reset");

    cmd_at[2] = 1;                 run_scn(5, 0, 0, "R3 CL5 single write");
    cmd_at[3] = 1;                 run_scn(8, 0, 0, "R3 CL8 single write");
    cmd_at[2] = 1;                 run_scn(6, 1, 0, "R5 early CL6 write");
    cmd_at[2] = 1; cmd_at[6] = 1;  run_scn(5, 0, 0, "R6 abutting writes");
    cmd_at[2] = 1; cmd_at[4] = 1;  run_scn(7, 1, 0, "R6 overlapping early writes");
    cmd_at[2] = 1;                 run_scn(3, 0, 0, "R2 CL3 normal");
    cmd_at[2] = 1;                 run_scn(4, 1, 0, "R4 CL4 early");
    cmd_at[2] = 2;                 run_scn(5, 0, 3, "R7 read gap3");
    cmd_at[2] = 2;                 run_scn(5, 0, 0, "R7 read gap0");
    cmd_at[2] = 2;                 run_scn(6, 1, 3, "R8 early read gap3");
    cmd_at[2] = 2; cmd_at[4] = 2;  run_scn(5, 0, 4, "R10 read restart");
    cmd_at[2] = 2; cmd_at[12] = 2; run_scn(5, 0, 2, "R9 reads only");
    cmd_at[2] = 1; cmd_at[12] = 2; run_scn(5, 0, 2, "R9 write then read");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule